// File: doc/BRIEF.md
# Cascaded Bus Clock Enable Divider

This block derives clock-enable pulses from a single source clock. A bus
enable is produced at 1/1, 1/2, 1/4 or 1/8 of the source rate. A peripheral
bus enable is then divided down from the bus enable, not from the source. The
overall peripheral ratio is therefore the product of two power-of-two factors,
which can reach 1/64. Every output is a one-cycle pulse in the source clock
domain, meant to qualify flops that run on that clock.

Two more dividers, each behind its own gate, count source cycles and serve a
timer group and a serial port. Five plain gates drive enables for other
peripherals: an I2C block, two UARTs, a wakeup capture timer and a quadrature
decoder. A plain gate holds its enable high in every source cycle while it is
open. All settings are loaded through a small write-only register port. They
reset to zero, which selects divide-by-1 everywhere and closes every gate.

Top module: `clkdiv_tree`

## Requirements
- R1: Bus ratio field (address 0, bits [1:0]). Codes 0, 1, 2 and 3 make `bus_en` pulse once every 1, 2, 4 and 8 source cycles.
- R2: Peripheral ratio field (address 0, bits [3:2]). Code p makes `pbus_en` pulse once every 2^p pulses of `bus_en`, so it pulses once every 2^(b+p) source cycles.
- R3: `pbus_en` is high only in cycles where `bus_en` is also high.
- R4: Timer settings are at address 1: divide code in bits [1:0], gate in bit 2. While the gate is open, `tmr_en` pulses once every 2^code source cycles. While it is closed, `tmr_en` stays low.
- R5: Serial settings are at address 1: divide code in bits [4:3], gate in bit 5. While the gate is open, `ser_en` pulses once every 2^code source cycles. While it is closed, `ser_en` stays low.
- R6: Address 1, bits [10:6], open the plain gates. Bit 6+i drives `gate_en[i]`, in the order I2C, UART A, UART B, wakeup capture, quadrature. An open gate holds its output high in every cycle; a closed gate holds it low.
- R7: After reset, `bus_en` and `pbus_en` are high in every cycle, and `tmr_en`, `ser_en` and `gate_en` are low.
- R8: A divider whose code changes counts the first cycle with the new code as count zero. With input enable always high and new code c, its first pulse comes 2^c-1 cycles after that cycle.
- R9: With code 0, a divider's output equals its input enable in every cycle, including the cycle in which the code changes.
- R10: A write is ignored when `wr_en` is low, and also when it goes to address 2 or 3. No output changes as a result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 11 | Write data |
| bus_en | output | 1 | Bus clock enable |
| pbus_en | output | 1 | Peripheral bus clock enable |
| tmr_en | output | 1 | Timer group clock enable |
| ser_en | output | 1 | Serial port clock enable |
| gate_en | output | 5 | Plain peripheral enables |

## Verification
A write is captured at the clock edge where `wr_en` is high. In the cycle after that edge, the affected divider sees the new code and treats that cycle as count zero. With code c, its first pulse therefore appears 2^c-1 cycles later. The bench samples every output at the falling edge. The restart check compares each of the cycles after the write edge, one by one, against that expected timing. Ratio checks first wait sixteen cycles for any restart to pass. They then count pulses over a 64-cycle window, which is a multiple of every possible ratio, so the expected count is exactly 64 divided by the ratio whatever the phase.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CODE_W  = 2;
  localparam int GATE_N  = 5;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 2 * CODE_W + 2 + GATE_N;

  localparam logic [ADDR_W-1:0] ADDR_BUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_PER = ADDR_W'(1);

  // field offsets in the peripheral word
  localparam int OFS_TMR_CODE = 0;
  localparam int OFS_TMR_ON   = CODE_W;
  localparam int OFS_SER_CODE = CODE_W + 1;
  localparam int OFS_SER_ON   = 2 * CODE_W + 1;
  localparam int OFS_GATES    = 2 * CODE_W + 2;

  typedef struct packed {
    logic [CODE_W-1:0] bus_code;
    logic [CODE_W-1:0] pbus_code;
    logic [CODE_W-1:0] tmr_code;
    logic              tmr_on;
    logic [CODE_W-1:0] ser_code;
    logic              ser_on;
    logic [GATE_N-1:0] gates;
  } ctrl_t;
endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/clkdiv_ctrl_regs.sv
module clkdiv_ctrl_regs
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_t             ctrl
);
  ctrl_t ctrl_q;
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en && wr_addr == ADDR_BUS) begin
      ctrl_d.bus_code  = wr_data[CODE_W-1:0];
      ctrl_d.pbus_code = wr_data[2*CODE_W-1:CODE_W];
    end else if (wr_en && wr_addr == ADDR_PER) begin
      ctrl_d.tmr_code = wr_data[OFS_TMR_CODE +: CODE_W];
      ctrl_d.tmr_on   = wr_data[OFS_TMR_ON];
      ctrl_d.ser_code = wr_data[OFS_SER_CODE +: CODE_W];
      ctrl_d.ser_on   = wr_data[OFS_SER_ON];
      ctrl_d.gates    = wr_data[OFS_GATES +: GATE_N];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;

  // R10: writes that are not strobed, or go to an unused address, leave settings alone
  a_r10_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr == ADDR_BUS || wr_addr == ADDR_PER)) |=> $stable(ctrl_q));
endmodule

// File: rtl/clkdiv_pow2.sv
module clkdiv_pow2 #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_en,
  input  logic [CODE_W-1:0] code,
  output logic              out_en
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_d;
  logic [CNT_W-1:0]  eff_cnt;
  logic [CNT_W-1:0]  last_cnt;
  logic [CNT_W:0]    ratio;
  logic              hit;

  always_comb begin
    ratio    = (CNT_W+1)'(1) << code;
    last_cnt = CNT_W'(ratio - 1'b1);
    eff_cnt  = (code != code_q) ? '0 : cnt_q;
    hit      = in_en && (eff_cnt == last_cnt);
    if (!in_en)   cnt_d = eff_cnt;
    else if (hit) cnt_d = '0;
    else          cnt_d = CNT_W'(eff_cnt + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      cnt_q  <= '0;
    end else begin
      code_q <= code;
      cnt_q  <= cnt_d;
    end
  end

  assign out_en = hit;

  // R9: code zero forwards the input enable unchanged
  a_r9_div1_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0) |-> (out_en == in_en));
  // R8: with a settled code the count stays inside the period
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (code == code_q) |-> (cnt_q <= last_cnt));
  // R1: a pulse never appears without an input enable
  a_r1_out_needs_in: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> in_en);
endmodule

// File: rtl/clkdiv_tree.sv
module clkdiv_tree
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              bus_en,
  output logic              pbus_en,
  output logic              tmr_en,
  output logic              ser_en,
  output logic [GATE_N-1:0] gate_en
);
  logic  rst_n_s;
  ctrl_t ctrl;
  logic  tmr_raw;
  logic  ser_raw;

  clkdiv_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  clkdiv_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl));

  // cascade: the peripheral divider counts bus enables
  clkdiv_pow2 #(.CODE_W(CODE_W)) u_bus (
    .clk(clk), .rst_n(rst_n_s), .in_en(1'b1), .code(ctrl.bus_code),
    .out_en(bus_en));

  clkdiv_pow2 #(.CODE_W(CODE_W)) u_pbus (
    .clk(clk), .rst_n(rst_n_s), .in_en(bus_en), .code(ctrl.pbus_code),
    .out_en(pbus_en));

  clkdiv_pow2 #(.CODE_W(CODE_W)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .in_en(1'b1), .code(ctrl.tmr_code),
    .out_en(tmr_raw));

  clkdiv_pow2 #(.CODE_W(CODE_W)) u_ser (
    .clk(clk), .rst_n(rst_n_s), .in_en(1'b1), .code(ctrl.ser_code),
    .out_en(ser_raw));

  assign tmr_en = tmr_raw & ctrl.tmr_on;
  assign ser_en = ser_raw & ctrl.ser_on;

  for (genvar g = 0; g < GATE_N; g++) begin : g_gate
    assign gate_en[g] = ctrl.gates[g];
  end

  // R3: the peripheral enable is a subset of the bus enable
  a_r3_pbus_in_bus: assert property (@(posedge clk) disable iff (!rst_n_s)
    pbus_en |-> bus_en);
  // R4: closed timer gate blocks its enable
  a_r4_tmr_closed: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ctrl.tmr_on |-> !tmr_en);
  // R5: closed serial gate blocks its enable
  a_r5_ser_closed: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ctrl.ser_on |-> !ser_en);
  // R2: with peripheral code zero both bus enables coincide
  a_r2_pbus_div1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctrl.pbus_code == '0 && $stable(ctrl.pbus_code)) |-> (pbus_en == bus_en));
endmodule

// File: tb/clkdiv_tree_test.sv
`timescale 1ns/1ps
module clkdiv_tree_test;
  import clkdiv_pkg::*;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              bus_en, pbus_en, tmr_en, ser_en;
  logic [GATE_N-1:0] gate_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int n_bus, n_pbus, n_tmr, n_ser, n_bad;

  clkdiv_tree uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bus_en(bus_en), .pbus_en(pbus_en),
    .tmr_en(tmr_en), .ser_en(ser_en), .gate_en(gate_en));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = ADDR_W'(addr);
    wr_data = DATA_W'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic window();
    repeat (16) @(negedge clk);
    n_bus = 0; n_pbus = 0; n_tmr = 0; n_ser = 0; n_bad = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      n_bus  += int'(bus_en);
      n_pbus += int'(pbus_en);
      n_tmr  += int'(tmr_en);
      n_ser  += int'(ser_en);
      if (pbus_en && !bus_en) n_bad++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: reset state
    window();
    chk("R7 bus_en count", n_bus, 64);
    chk("R7 pbus_en count", n_pbus, 64);
    chk("R7 tmr_en count", n_tmr, 0);
    chk("R7 ser_en count", n_ser, 0);
    chk("R7 gate_en", int'(gate_en), 0);

    // R10: unstrobed write and writes to unused addresses
    @(negedge clk);
    wr_en = 1'b0; wr_addr = ADDR_W'(0); wr_data = DATA_W'(15);
    @(negedge clk);
    wr_addr = ADDR_W'(1); wr_data = '1;
    @(negedge clk);
    wr(2, (1 << DATA_W) - 1);
    wr(3, (1 << DATA_W) - 1);
    window();
    chk("R10 bus_en count", n_bus, 64);
    chk("R10 pbus_en count", n_pbus, 64);
    chk("R10 tmr_en count", n_tmr, 0);
    chk("R10 ser_en count", n_ser, 0);
    chk("R10 gate_en", int'(gate_en), 0);

    // R1 R2 R3 R9: sweep of both cascaded codes
    for (int b = 0; b < 4; b++) begin
      for (int p = 0; p < 4; p++) begin
        wr(0, (p << 2) | b);
        window();
        chk($sformatf("R1 bus code %0d", b), n_bus, 64 >> b);
        chk($sformatf("R2 bus %0d per %0d", b, p), n_pbus, 64 >> (b + p));
        chk("R3 pbus outside bus", n_bad, 0);
      end
    end

    // R8: restart on code change, from code 0 to code 2
    wr(0, 0);
    repeat (8) @(negedge clk);
    wr(0, 2);
    for (int c = 0; c < 8; c++) begin
      chk($sformatf("R8 bus_en cycle %0d after write", c), int'(bus_en),
          (c == 3 || c == 7) ? 1 : 0);
      @(negedge clk);
    end

    // R9: code-change cycle back to 0 passes every cycle
    wr(0, 0);
    for (int c = 0; c < 4; c++) begin
      chk("R9 bus_en passthrough", int'(bus_en), 1);
      chk("R9 pbus_en passthrough", int'(pbus_en), 1);
      @(negedge clk);
    end

    // R4 R5: gated dividers, opposite codes
    for (int t = 0; t < 4; t++) begin
      int s;
      s = 3 - t;
      wr(1, t | (1 << OFS_TMR_ON) | (s << OFS_SER_CODE) | (1 << OFS_SER_ON));
      window();
      chk($sformatf("R4 tmr code %0d", t), n_tmr, 64 >> t);
      chk($sformatf("R5 ser code %0d", s), n_ser, 64 >> s);
    end
    wr(1, 1 | (2 << OFS_SER_CODE));
    window();
    chk("R4 tmr closed", n_tmr, 0);
    chk("R5 ser closed", n_ser, 0);

    // R6: each plain gate alone, then all
    for (int g = 0; g < GATE_N; g++) begin
      wr(1, 1 << (OFS_GATES + g));
      repeat (2) @(negedge clk);
      chk($sformatf("R6 gate %0d", g), int'(gate_en), 1 << g);
      chk("R6 tmr stays closed", int'(tmr_en), 0);
    end
    wr(1, ((1 << GATE_N) - 1) << OFS_GATES);
    window();
    chk("R6 all gates open", int'(gate_en), (1 << GATE_N) - 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule